// File: doc/BRIEF.md
# Serial D-Channel Frame Transmitter

This block turns packets handed over one byte at a time into a bit-synchronous HDLC-style stream for a 16 kbit/s signalling channel. Each time the channel strobe fires it puts exactly one new bit on its serial output. A frame is framed by flag octets. Its content, which is the payload followed by a 16-bit frame check sequence, is protected against flag imitation by zero insertion. Between frames the line carries an idle pattern that software can select: continuous ones, or back-to-back flags.

The host feeds the block through a valid/ready byte handshake with a last-byte marker, backed by a single holding register. A host-driven abort input replaces whatever is on the line with a repeating seven-ones-then-zero pattern and raises a one-cycle status pulse each time the pattern completes. If the host does not supply the next payload byte in time, the block aborts the frame by itself in the same way.

Top module: `dch_hdlc_tx`

## Requirements
- R1: While `rst` is high at a clock edge, `tx_bit` becomes 1, `tx_ready` becomes 1 and `abort_pulse` becomes 0.
- R2: `tx_bit` changes only at a clock edge where `bit_stb` is high, and each such edge presents exactly one new line bit.
- R3: A frame starts only at an idle strobe whose position is a multiple of 8. Positions are counted from reset, from the end of a closing flag, or from the end of an abort. A frame also needs a byte in the holding register. Its first eight line bits are the flag 0,1,1,1,1,1,1,0.
- R4: Payload bytes go out least significant bit first, in the order they were accepted.
- R5: The check value F is preset to 16'hFFFF. For every payload bit b, F is updated to (F>>1) XOR (16'h8408 if F[0]^b else 0); this is the reflected form of x^16+x^12+x^5+1. After the last payload bit, the 16 bits ~F[0], ~F[1] … ~F[15] are sent, which puts the highest-order coefficient first.
- R6: Within payload and check bits, a 0 is inserted after every run of five consecutive 1s. This includes a run that ends on the last check bit, in which case the 0 is inserted before the closing flag. Flags are never stuffed.
- R7: The closing flag 0,1,1,1,1,1,1,0 follows the check bits. Idle then sends all 1s when `idle_flag_sel`=0 and repeated flags when `idle_flag_sel`=1.
- R8: When `abort_req` is high at a strobe and no abort is running, the line immediately sends 1,1,1,1,1,1,1,0 and repeats that pattern while `abort_req` stays high. When `abort_req` is low at the strobe that sends the 0, the block returns to idle. Any frame in progress and any held byte are discarded.
- R9: `abort_pulse` is high for one clock, at the same edge that outputs the 0 ending each abort pattern, and is low otherwise.
- R10: When the last bit of a byte not marked last is sent and the holding register is empty, the very next strobe begins one abort pattern, with its status pulse.
- R11: `tx_ready` is high exactly when the holding register is empty and no abort pattern is running. A byte is taken at a clock edge where `tx_valid` and `tx_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle strobe marking each channel bit slot |
| idle_flag_sel | input | 1 | 0 selects ones idle, 1 selects flag idle |
| abort_req | input | 1 | Host transmit abort command (level) |
| tx_valid | input | 1 | Host byte valid |
| tx_data | input | 8 | Host payload byte |
| tx_last | input | 1 | Marks the final payload byte of a frame |
| tx_ready | output | 1 | Holding register can take a byte |
| tx_bit | output | 1 | Serial line bit |
| abort_pulse | output | 1 | One-cycle pulse per completed abort pattern |

## Verification
The hardest situation to reach is a check sequence that ends in a run of five ones, because that forces a stuffed zero in front of the closing flag. No single chosen payload targets it reliably. The stimulus therefore streams many frames of random length and content through a reference model that follows the line bit by bit, so this case, long payload runs and back-to-back frames in both idle modes all come up along the way. Underrun is produced by withholding the rest of a frame that has no last marker. Commanded abort is raised only after feeding has stopped, so that the flushed holding byte is the only byte the model has to discard.

// File: rtl/dch_tx_pkg.sv
package dch_tx_pkg;

    localparam int          BYTE_W      = 8;
    localparam int          FCS_W       = 16;
    localparam int          CNT_W       = 4;
    localparam int          RUN_LIMIT   = 5;
    localparam logic [15:0] FCS_POLY    = 16'h8408;
    localparam logic [15:0] FCS_PRESET  = 16'hFFFF;
    localparam logic [CNT_W-1:0] OCTET_END = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FCS_END   = CNT_W'(FCS_W - 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPEN, ST_BODY, ST_FCS, ST_CLOSE, ST_ABORT
    } txst_e;

    typedef struct packed {
        logic              last;
        logic [BYTE_W-1:0] data;
    } txbyte_t;

    function automatic logic [FCS_W-1:0] fcs_step(logic [FCS_W-1:0] c, logic b);
        return (c >> 1) ^ ((c[0] ^ b) ? FCS_POLY : '0);
    endfunction

    // flag octet: 0 at both ends, 1 in between
    function automatic logic flag_bit(logic [2:0] pos);
        return (pos != 3'd0) && (pos != 3'd7);
    endfunction

endpackage

// File: rtl/dch_tx_hold.sv
module dch_tx_hold
    import dch_tx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  txbyte_t wr_byte,
    input  logic    take,
    input  logic    flush,
    input  logic    block,
    output logic    full,
    output logic    ready,
    output txbyte_t rd_byte
);

    assign ready = !full && !block;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            full <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && ready) begin
            full    <= 1'b1;
            rd_byte <= wr_byte;
        end
    end

    // R11
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !take && !flush) |=> (full && $stable(rd_byte)));

    // R11
    hold_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ready && !flush) |=> full);

endmodule

// File: rtl/dch_tx_fcs.sv
module dch_tx_fcs
    import dch_tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic preset,
    input  logic feed,
    input  logic feed_bit,
    input  logic drain,
    output logic fcs_bit
);

    logic [FCS_W-1:0] crc;

    always_ff @(posedge clk) begin
        if (rst || preset)
            crc <= FCS_PRESET;
        else if (feed)
            crc <= fcs_step(crc, feed_bit);
        else if (drain)
            crc <= {1'b1, crc[FCS_W-1:1]};
    end

    assign fcs_bit = ~crc[0];

    // R5
    fcs_mode_chk: assert property (@(posedge clk) disable iff (rst)
        !(feed && drain));

endmodule

// File: rtl/dch_hdlc_tx.sv
module dch_hdlc_tx
    import dch_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_stb,
    input  logic       idle_flag_sel,
    input  logic       abort_req,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    input  logic       tx_last,
    output logic       tx_ready,
    output logic       tx_bit,
    output logic       abort_pulse
);

    txst_e             st;
    logic [CNT_W-1:0]  cnt;
    logic [2:0]        ones;
    logic [BYTE_W-1:0] sh;
    logic              cur_last;

    logic    hold_full, take, flush, preset, feed, drain, fcs_bit, nbit;
    txbyte_t wr_b, hold_b;

    assign wr_b = '{last: tx_last, data: tx_data};

    dch_tx_hold i_hold (
        .clk(clk), .rst(rst), .wr_en(tx_valid), .wr_byte(wr_b),
        .take(take), .flush(flush), .block(st == ST_ABORT),
        .full(hold_full), .ready(tx_ready), .rd_byte(hold_b)
    );

    dch_tx_fcs i_fcs (
        .clk(clk), .rst(rst), .preset(preset), .feed(feed),
        .feed_bit(sh[0]), .drain(drain), .fcs_bit(fcs_bit)
    );

    logic go_abort, stuff, start, octet_end;
    assign go_abort  = abort_req && (st != ST_ABORT);
    assign stuff     = (ones == 3'(RUN_LIMIT)) &&
                       (st == ST_BODY || st == ST_FCS || (st == ST_CLOSE && cnt == '0));
    assign start     = (st == ST_IDLE) && (cnt[2:0] == 3'd0) && hold_full;
    assign octet_end = (cnt == OCTET_END);

    always_comb begin
        nbit   = 1'b1;
        take   = 1'b0;
        flush  = 1'b0;
        preset = 1'b0;
        feed   = 1'b0;
        drain  = 1'b0;
        if (go_abort) begin
            flush = bit_stb;
        end else if (stuff) begin
            nbit = 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        nbit   = 1'b0;
                        take   = bit_stb;
                        preset = bit_stb;
                    end else begin
                        nbit = idle_flag_sel ? flag_bit(cnt[2:0]) : 1'b1;
                    end
                end
                ST_OPEN, ST_CLOSE: nbit = flag_bit(cnt[2:0]);
                ST_BODY: begin
                    nbit = sh[0];
                    feed = bit_stb;
                    take = bit_stb && octet_end && !cur_last && hold_full;
                end
                ST_FCS: begin
                    nbit  = fcs_bit;
                    drain = bit_stb;
                end
                ST_ABORT: nbit = (cnt[2:0] != 3'd7);
                default:  nbit = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        abort_pulse <= 1'b0;
        if (rst) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            ones     <= '0;
            sh       <= '0;
            cur_last <= 1'b0;
            tx_bit   <= 1'b1;
        end else if (bit_stb) begin
            tx_bit <= nbit;
            if (go_abort) begin
                st  <= ST_ABORT;
                cnt <= CNT_W'(1);
            end else if (stuff) begin
                ones <= '0;
            end else begin
                unique case (st)
                    ST_IDLE: begin
                        if (start) begin
                            st       <= ST_OPEN;
                            cnt      <= CNT_W'(1);
                            sh       <= hold_b.data;
                            cur_last <= hold_b.last;
                            ones     <= '0;
                        end else begin
                            cnt <= {1'b0, cnt[2:0] + 3'd1};
                        end
                    end
                    ST_OPEN: begin
                        if (octet_end) begin
                            st  <= ST_BODY;
                            cnt <= '0;
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_BODY: begin
                        ones <= sh[0] ? ones + 3'd1 : 3'd0;
                        sh   <= sh >> 1;
                        if (octet_end) begin
                            cnt <= '0;
                            if (cur_last) begin
                                st <= ST_FCS;
                            end else if (hold_full) begin
                                sh       <= hold_b.data;
                                cur_last <= hold_b.last;
                            end else begin
                                st <= ST_ABORT;
                            end
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_FCS: begin
                        ones <= fcs_bit ? ones + 3'd1 : 3'd0;
                        if (cnt == FCS_END) begin
                            st  <= ST_CLOSE;
                            cnt <= '0;
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_CLOSE: begin
                        if (octet_end) begin
                            st  <= ST_IDLE;
                            cnt <= '0;
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_ABORT: begin
                        if (cnt[2:0] == 3'd7) begin
                            abort_pulse <= 1'b1;
                            cnt         <= '0;
                            if (!abort_req) st <= ST_IDLE;
                        end else cnt <= cnt + 1'b1;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // R2
    stb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_stb |=> $stable(tx_bit));

    // R9
    pulse_zero_chk: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> !tx_bit);

    // R9
    pulse_stb_chk: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> $past(bit_stb));

    // R6
    run_len_chk: assert property (@(posedge clk) disable iff (rst)
        ones <= 3'(RUN_LIMIT));

    // R8
    abort_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ABORT && cnt[2:0] != 3'd7 && bit_stb) |=> tx_bit);

    // R10
    underrun_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BODY && bit_stb && !go_abort && !stuff && octet_end
         && !cur_last && !hold_full) |=> (st == ST_ABORT && cnt == '0));

endmodule

// File: tb/test_dch_hdlc_tx.sv
module test_dch_hdlc_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_stb = 1'b0;
    logic       idle_flag_sel = 1'b0;
    logic       abort_req = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_last = 1'b0;
    logic       tx_ready, tx_bit, abort_pulse;

    always #5 clk = ~clk;

    dch_hdlc_tx i_dch_hdlc_tx (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .idle_flag_sel(idle_flag_sel),
        .abort_req(abort_req), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready), .tx_bit(tx_bit),
        .abort_pulse(abort_pulse)
    );

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    logic [8:0] fq[$];      // bytes waiting to be offered {last, data}
    logic [8:0] acc_q[$];   // bytes the block has taken but not started

    // reference model state
    int          m_st = 0;  // 0 idle 1 open 2 content 3 close 4 abort
    int          m_pos = 0;
    int          m_ones = 0;
    logic [15:0] m_crc = 16'hFFFF;
    logic        m_bits[$];
    logic        m_in_fcs = 1'b0;
    logic        m_last = 1'b0;
    logic        m_ur = 1'b0;
    logic        exp_bit = 1'b1;

    logic s_rst = 1'b1, s_abort = 1'b0, s_idle = 1'b0, s_stb = 1'b0, rdy_prev = 1'b0;
    int   stb_div = 0;

    function automatic logic [15:0] crc_bit(logic [15:0] c, logic b);
        logic fb;
        fb = c[0] ^ b;
        c  = {1'b0, c[15:1]};
        if (fb) c = c ^ 16'h8408;
        return c;
    endfunction

    task automatic check(input logic act, input logic exp, input string rq, input string what);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", rq, what, cyc, act, exp);
        end
    endtask

    task automatic load_byte();
        logic [8:0] x;
        x = acc_q.pop_front();
        m_last = x[8];
        m_in_fcs = 1'b0;
        for (int i = 0; i < 8; i++) m_bits.push_back(x[i]);
    endtask

    task automatic model_step(output logic eb, output logic ep, output string rq);
        logic b;
        eb = 1'b1; ep = 1'b0; rq = "R7";
        if (s_abort && m_st != 4) begin
            rq = "R8"; m_st = 4; m_pos = 1; m_ur = 1'b0;
            acc_q.delete(); m_bits.delete();
            return;
        end
        case (m_st)
            0: if (m_pos == 0 && acc_q.size() != 0) begin
                   eb = 1'b0; rq = "R3"; m_st = 1; m_pos = 1;
                   m_bits.delete(); load_byte(); m_crc = 16'hFFFF; m_ones = 0;
               end else begin
                   eb = s_idle ? (m_pos != 0 && m_pos != 7) : 1'b1;
                   rq = "R7"; m_pos = (m_pos + 1) % 8;
               end
            1: begin
                   eb = (m_pos != 7); rq = "R3";
                   if (m_pos == 7) m_st = 2; else m_pos++;
               end
            2: if (m_ones == 5) begin
                   eb = 1'b0; rq = "R6"; m_ones = 0;
               end else begin
                   b = m_bits.pop_front();
                   eb = b; rq = m_in_fcs ? "R5" : "R4";
                   m_ones = b ? m_ones + 1 : 0;
                   if (!m_in_fcs) m_crc = crc_bit(m_crc, b);
                   if (m_bits.size() == 0) begin
                       if (m_in_fcs) begin m_st = 3; m_pos = 0; end
                       else if (m_last) begin
                           for (int i = 0; i < 16; i++) m_bits.push_back(~m_crc[i]);
                           m_in_fcs = 1'b1;
                       end else if (acc_q.size() != 0) load_byte();
                       else begin m_st = 4; m_pos = 0; m_ur = 1'b1; end
                   end
               end
            3: if (m_pos == 0 && m_ones == 5) begin
                   eb = 1'b0; rq = "R6"; m_ones = 0;
               end else begin
                   eb = (m_pos != 0 && m_pos != 7); rq = "R7";
                   if (m_pos == 7) begin m_st = 0; m_pos = 0; end else m_pos++;
               end
            default: begin
                   eb = (m_pos != 7); rq = m_ur ? "R10" : "R8";
                   if (m_pos == 7) begin
                       ep = 1'b1; m_pos = 0;
                       if (!s_abort) m_st = 0;
                   end else m_pos++;
               end
        endcase
    endtask

    // everything on the falling edge: compare, model, feeder, strobe
    always @(negedge clk) begin
        logic  ep;
        string rq;
        cyc++;
        if (s_rst) begin
            m_st = 0; m_pos = 0; m_ones = 0; m_bits.delete(); acc_q.delete();
            exp_bit = 1'b1;
        end else begin
            ep = 1'b0; rq = "R2";
            if (s_stb) model_step(exp_bit, ep, rq);
            check(tx_bit, exp_bit, rq, "line bit");
            check(abort_pulse, ep, "R9", "abort pulse");
            if (tx_valid && rdy_prev) acc_q.push_back(fq.pop_front());
            check(tx_ready, (acc_q.size() == 0) && (m_st != 4), "R11", "ready");
        end
        if (fq.size() != 0) begin
            tx_valid = 1'b1; {tx_last, tx_data} = fq[0];
        end else begin
            tx_valid = 1'b0;
        end
        rdy_prev = tx_ready;
        stb_div  = (stb_div + 1) % 4;
        bit_stb  = (stb_div == 0);
        s_stb    = bit_stb;
        s_rst    = rst;
        s_abort  = abort_req;
        s_idle   = idle_flag_sel;
        if (cyc > 150000) begin
            mismatched++;
            $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic put(input logic [7:0] b, input logic last);
        fq.push_back({last, b});
    endtask

    task automatic wait_done();
        do @(posedge clk); while (!(fq.size() == 0 && acc_q.size() == 0 && m_st == 0 && !tx_valid));
        repeat (48) @(posedge clk);
        #1;
    endtask

    task automatic wait_strobes(input int n);
        repeat (n * 4) @(posedge clk);
        #1;
    endtask

    initial begin
        int n;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        // R1 reset state
        check(tx_bit, 1'b1, "R1", "reset line bit");
        check(tx_ready, 1'b1, "R1", "reset ready");
        check(abort_pulse, 1'b0, "R1", "reset pulse");
        @(posedge clk); #1;
        wait_strobes(20);                              // R7 mark idle

        put(8'h12, 0); put(8'h34, 0); put(8'h56, 1);   // R4 R5
        wait_done();
        put(8'hFF, 0); put(8'hFF, 0); put(8'h7E, 0); put(8'hFF, 1);  // R6
        wait_done();
        put(8'h00, 1);
        wait_done();

        idle_flag_sel = 1'b1;                          // R7 flag idle
        wait_strobes(20);
        put(8'hF8, 0); put(8'h1F, 0); put(8'h3E, 1);
        put(8'hA5, 1);                                 // back-to-back frame, R3
        wait_done();

        for (int f = 0; f < 24; f++) begin             // random content, R5 R6
            idle_flag_sel = $urandom_range(0, 1);
            n = $urandom_range(1, 6);
            for (int k = 0; k < n; k++)
                put((f % 3 == 0) ? 8'hFF ^ 8'($urandom_range(0, 3)) : 8'($urandom_range(0, 255)),
                    k == n - 1);
            wait_done();
        end

        idle_flag_sel = 1'b0;                          // R8 mid-frame abort held
        for (int k = 0; k < 10; k++) put(8'h3C + 8'(k), k == 9);
        wait_strobes(40);
        fq.delete();
        repeat (3) @(posedge clk);
        #1 abort_req = 1'b1;
        wait_strobes(21);
        abort_req = 1'b0;
        wait_done();

        abort_req = 1'b1;                              // R8 R9 abort from idle
        @(posedge clk); #1;
        repeat (4) @(posedge clk);
        #1 abort_req = 1'b0;
        wait_done();

        put(8'hA5, 0); put(8'h5A, 0);                  // R10 underrun
        wait_done();
        put(8'hC3, 1);                                 // recovery
        wait_done();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule